// File: doc/BRIEF.md
# Host-to-PCI Address Decoder and Translator

This block classifies every transaction from the host processor bus, and every inbound transaction from the PCI side, by its address. For host transactions it picks one of several destinations: system memory, PCI memory space, the PCI I/O window, the configuration-address or configuration-data register alias, or an error or silent response for addresses that nothing claims. For PCI destinations it also forms the 32-bit address that goes out on the PCI bus. The PCI I/O window has two translation modes. The contiguous mode clears the top address byte. The discontiguous mode gathers two bit fields of the host address into the low 16 bits.

For inbound PCI traffic the block only decides whether a system memory cycle takes place. Memory accesses below the legacy hole, and from 1 MiB up to a programmable top address, reach system memory. The legacy hole itself reaches system memory only when a control bit allows it. Inbound I/O accesses never reach system memory. Decoding is registered. A request is accepted when the block is idle, and the result is held on the response side until it is acknowledged. The mode bits are captured at acceptance.

Top module: `hpci_bridge_dec`

## Requirements
- R1: While reset is asserted, and after reset until the first request, rsp_valid=0, rsp_err=0 and req_ready=1.
- R2: A request is accepted on a rising edge where req_valid=1 and req_ready=1. rsp_valid is 1 from the next cycle on. While rsp_valid=1, req_ready=0 and every response output stays stable until rsp_ack=1 is seen on an edge. After that edge rsp_valid=0.
- R3: A host address below 0x40000000 and outside the hole 0x000A0000–0x000FFFFF gives target code 1 (system memory), with rsp_addr equal to the host address.
- R4: A host address in the hole gives code 1 with the address unchanged when mode_hole_host_pci=0. When mode_hole_host_pci=1 it gives code 2 (PCI memory), with rsp_addr = {8'h00, addr[23:0]}.
- R5: Host addresses 0x80000000–0xFDFFFFFF and 0xFEF00000–0xFFFFFFFF give code 2, with rsp_addr = {8'h00, addr[23:0]}.
- R6: With mode_discontig=0, host addresses 0xFE000000–0xFE00FFFF and 0xFE800000–0xFEBFFFFF give code 3 (PCI I/O), with rsp_addr = {8'h00, addr[23:0]}. Addresses 0xFE010000–0xFE7FFFFF are reserved and are handled as in R9/R10.
- R7: With mode_discontig=1, the whole window 0xFE000000–0xFEBFFFFF gives code 3. rsp_addr is 16 zero bits, then host bits 9..19, then host bits 27..31, where bit 0 is the most significant (that is {16'h0, addr[22:12], addr[4:0]}).
- R8: Host 0xFEC00000–0xFEDFFFFF gives code 4 (configuration address alias) and 0xFEE00000–0xFEEFFFFF gives code 5 (configuration data alias), whatever the low bits. rsp_addr is 0 for both.
- R9: A host address in 0x40000000–0x7FFFFFFF, or a reserved address, with mode_err_en=1 gives code 6 (error), rsp_addr=0 and rsp_fill=0. rsp_err is 1 in the first response cycle only.
- R10: The same addresses with mode_err_en=0 give code 0 (no target) and rsp_err=0, with rsp_addr=0. A read gives rsp_fill=1 and rsp_rdata all ones. A write gives rsp_fill=0 and rsp_rdata zero, so it is dropped.
- R11: An inbound memory request (req_inbound=1, req_io=0) gives code 1 with rsp_addr = address for addresses below 0x000A0000, and for addresses from 0x00100000 to mode_mem_top inclusive. In the hole it gives code 1 when mode_hole_pci_sys=1 and code 0 otherwise. Every other address gives code 0, with rsp_addr=0.
- R12: An inbound I/O request (req_inbound=1, req_io=1) always gives code 0 with rsp_addr=0 and rsp_err=0.
- R13: The mode inputs act only at acceptance. Changing them while a response is held does not change that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_inbound | input | 1 | 1 = request comes from the PCI side |
| req_io | input | 1 | Inbound request is to I/O space |
| mode_discontig | input | 1 | I/O window translation: 1 = bit gathering |
| mode_err_en | input | 1 | Unclaimed addresses raise an error |
| mode_hole_host_pci | input | 1 | Host hole accesses go to PCI memory |
| mode_hole_pci_sys | input | 1 | Inbound hole accesses reach system memory |
| mode_mem_top | input | 32 | Highest inbound system memory address above 1 MiB |
| rsp_valid | output | 1 | Response held |
| rsp_ack | input | 1 | Downstream has taken the response |
| rsp_target | output | 3 | Target code (0 none, 1 sysmem, 2 PCI mem, 3 PCI I/O, 4 cfg addr, 5 cfg data, 6 error) |
| rsp_addr | output | 32 | Translated address |
| rsp_err | output | 1 | One-cycle error strobe |
| rsp_fill | output | 1 | Read is answered with all ones |
| rsp_rdata | output | DATA_W | Override read data |

## Verification
The bench builds the block with its default parameters: the bit-gathering variant compiled in, a 64-bit override data path, and the default window bounds. With these defaults, both I/O translation modes, the reserved window and every window edge can be reached at run time. Random addresses are biased toward the top byte 0xFE, the low megabyte and the unclaimed window, so that every target code appears often. Directed cases hit each bound exactly. The mode inputs are flipped while a response is held.

// File: rtl/hpci_pkg.sv
`timescale 1ns/1ps
package hpci_pkg;

   localparam int unsigned PA_W = 32;

   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_SYSMEM = 3'd1,
      TGT_PCIMEM = 3'd2,
      TGT_PCIIO  = 3'd3,
      TGT_CFGADR = 3'd4,
      TGT_CFGDAT = 3'd5,
      TGT_ERR    = 3'd6
   } tgt_e;

   typedef struct packed {
      tgt_e            tgt;
      logic [PA_W-1:0] addr;
      logic            fill;
      logic            err;
   } dec_s;

   // host-side windows, index into the window compare array
   localparam int unsigned NWIN    = 6;
   localparam int unsigned WI_HOLE = 0;
   localparam int unsigned WI_UNCL = 1;
   localparam int unsigned WI_IOW  = 2;
   localparam int unsigned WI_RSV  = 3;
   localparam int unsigned WI_CFGA = 4;
   localparam int unsigned WI_CFGD = 5;

endpackage

// File: rtl/hpci_io_xlate.sv
`timescale 1ns/1ps
// Forms the PCI I/O address from the low part of the host address.
module hpci_io_xlate
   import hpci_pkg::*;
#(
   parameter bit          DISCONTIG_EN = 1'b1,
   parameter int unsigned CLR_BITS     = 8,
   // gathered fields, numbered with bit 0 as the most significant host bit
   parameter int unsigned F1_FIRST     = 9,
   parameter int unsigned F1_LAST      = 19,
   parameter int unsigned F2_FIRST     = 27,
   parameter int unsigned F2_LAST      = 31
)(
   input  logic [PA_W-CLR_BITS-1:0] low_i,
   input  logic                     discontig_i,
   output logic [PA_W-1:0]          pci_o,
   output logic                     gather_o
);
   localparam int unsigned LOW_W = PA_W - CLR_BITS;
   localparam int unsigned F1_W  = F1_LAST - F1_FIRST + 1;
   localparam int unsigned F2_W  = F2_LAST - F2_FIRST + 1;
   localparam int unsigned PAD_W = PA_W - F1_W - F2_W;
   localparam int unsigned F1_HI = PA_W - 1 - F1_FIRST;
   localparam int unsigned F1_LO = PA_W - 1 - F1_LAST;
   localparam int unsigned F2_HI = PA_W - 1 - F2_FIRST;
   localparam int unsigned F2_LO = PA_W - 1 - F2_LAST;

   if (CLR_BITS == 0 || CLR_BITS >= PA_W) begin : g_bad_clr
      $error("hpci_io_xlate: CLR_BITS out of range");
   end
   if (F1_LAST < F1_FIRST || F2_LAST < F2_FIRST || F2_FIRST <= F1_LAST) begin : g_bad_fld
      $error("hpci_io_xlate: gather fields must be ordered and disjoint");
   end
   if (F1_FIRST < CLR_BITS || F2_LAST >= PA_W) begin : g_bad_rng
      $error("hpci_io_xlate: gather fields must lie in the low address part");
   end

   logic [PA_W-1:0] cleared;
   logic [PA_W-1:0] gathered;

   assign cleared = {{CLR_BITS{1'b0}}, low_i};

   if (DISCONTIG_EN) begin : g_gather
      assign gathered = {{PAD_W{1'b0}}, low_i[F1_HI:F1_LO], low_i[F2_HI:F2_LO]};
      assign gather_o = discontig_i;
   end else begin : g_contig
      assign gathered = cleared;
      assign gather_o = discontig_i & 1'b0;
   end

   assign pci_o = gather_o ? gathered : cleared;

   // keep widths honest for the derived slices
   if (F1_HI >= LOW_W) begin : g_bad_slice
      $error("hpci_io_xlate: field one exceeds the translated part");
   end
endmodule

// File: rtl/hpci_host_dec.sv
`timescale 1ns/1ps
// Host-side address classification and translation (combinational).
module hpci_host_dec
   import hpci_pkg::*;
#(
   parameter logic [PA_W-1:0] HOLE_LO = 32'h000A_0000,
   parameter logic [PA_W-1:0] HOLE_HI = 32'h000F_FFFF,
   parameter logic [PA_W-1:0] UNCL_LO = 32'h4000_0000,
   parameter logic [PA_W-1:0] UNCL_HI = 32'h7FFF_FFFF,
   parameter logic [PA_W-1:0] IOW_LO  = 32'hFE00_0000,
   parameter logic [PA_W-1:0] IOW_HI  = 32'hFEBF_FFFF,
   parameter logic [PA_W-1:0] RSV_LO  = 32'hFE01_0000,
   parameter logic [PA_W-1:0] RSV_HI  = 32'hFE7F_FFFF,
   parameter logic [PA_W-1:0] CFGA_LO = 32'hFEC0_0000,
   parameter logic [PA_W-1:0] CFGA_HI = 32'hFEDF_FFFF,
   parameter logic [PA_W-1:0] CFGD_LO = 32'hFEE0_0000,
   parameter logic [PA_W-1:0] CFGD_HI = 32'hFEEF_FFFF,
   parameter int unsigned     CLR_BITS     = 8,
   parameter bit              DISCONTIG_EN = 1'b1
)(
   input  logic [PA_W-1:0] addr_i,
   input  logic            write_i,
   input  logic            discontig_i,
   input  logic            err_en_i,
   input  logic            hole_pci_i,
   output dec_s            dec_o
);
   localparam logic [PA_W-1:0] WLO [NWIN] = '{HOLE_LO, UNCL_LO, IOW_LO, RSV_LO, CFGA_LO, CFGD_LO};
   localparam logic [PA_W-1:0] WHI [NWIN] = '{HOLE_HI, UNCL_HI, IOW_HI, RSV_HI, CFGA_HI, CFGD_HI};

   if (HOLE_HI >= UNCL_LO || UNCL_HI >= IOW_LO) begin : g_bad_order
      $error("hpci_host_dec: hole, unclaimed and I/O windows must ascend");
   end
   if (RSV_LO < IOW_LO || RSV_HI > IOW_HI) begin : g_bad_rsv
      $error("hpci_host_dec: reserved range must sit inside the I/O window");
   end
   if (CFGA_LO <= IOW_HI || CFGD_LO <= CFGA_HI) begin : g_bad_cfg
      $error("hpci_host_dec: configuration aliases must follow the I/O window");
   end

   logic [NWIN-1:0] hit;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      if (WLO[w] > WHI[w]) begin : g_bad
         $error("hpci_host_dec: window bounds inverted");
      end
      assign hit[w] = (addr_i >= WLO[w]) && (addr_i <= WHI[w]);
   end

   logic [PA_W-1:0] io_addr;
   logic [PA_W-1:0] top_clr;
   logic            gather;

   hpci_io_xlate #(
      .DISCONTIG_EN (DISCONTIG_EN),
      .CLR_BITS     (CLR_BITS)
   ) u_xlate (
      .low_i       (addr_i[PA_W-CLR_BITS-1:0]),
      .discontig_i (discontig_i),
      .pci_o       (io_addr),
      .gather_o    (gather)
   );

   assign top_clr = {{CLR_BITS{1'b0}}, addr_i[PA_W-CLR_BITS-1:0]};

   logic unclaimed;
   dec_s d;

   always_comb begin
      d         = '0;
      unclaimed = 1'b0;
      if (hit[WI_UNCL]) begin
         unclaimed = 1'b1;
      end else if (addr_i < UNCL_LO) begin
         if (hit[WI_HOLE] && hole_pci_i) begin
            d.tgt  = TGT_PCIMEM;
            d.addr = top_clr;
         end else begin
            d.tgt  = TGT_SYSMEM;
            d.addr = addr_i;
         end
      end else if (hit[WI_IOW]) begin
         if (!gather && hit[WI_RSV]) begin
            unclaimed = 1'b1;
         end else begin
            d.tgt  = TGT_PCIIO;
            d.addr = io_addr;
         end
      end else if (hit[WI_CFGA]) begin
         d.tgt = TGT_CFGADR;
      end else if (hit[WI_CFGD]) begin
         d.tgt = TGT_CFGDAT;
      end else begin
         d.tgt  = TGT_PCIMEM;
         d.addr = top_clr;
      end

      if (unclaimed) begin
         if (err_en_i) begin
            d.tgt = TGT_ERR;
            d.err = 1'b1;
         end else begin
            d.tgt  = TGT_NONE;
            d.fill = !write_i;
         end
      end
   end

   assign dec_o = d;
endmodule

// File: rtl/hpci_pci_dec.sv
`timescale 1ns/1ps
// Inbound PCI classification: system memory cycle or none.
module hpci_pci_dec
   import hpci_pkg::*;
#(
   parameter logic [PA_W-1:0] HOLE_LO = 32'h000A_0000,
   parameter logic [PA_W-1:0] HOLE_HI = 32'h000F_FFFF
)(
   input  logic [PA_W-1:0] addr_i,
   input  logic            io_i,
   input  logic            hole_sys_i,
   input  logic [PA_W-1:0] top_i,
   output dec_s            dec_o
);
   if (HOLE_LO > HOLE_HI || HOLE_LO == '0) begin : g_bad_hole
      $error("hpci_pci_dec: hole must be non-empty and start above zero");
   end

   logic sys_hit;

   always_comb begin
      sys_hit = 1'b0;
      if (!io_i) begin
         if (addr_i < HOLE_LO)
            sys_hit = 1'b1;
         else if (addr_i <= HOLE_HI)
            sys_hit = hole_sys_i;
         else
            sys_hit = (addr_i <= top_i);
      end
   end

   always_comb begin
      dec_o = '0;
      if (sys_hit) begin
         dec_o.tgt  = TGT_SYSMEM;
         dec_o.addr = addr_i;
      end
   end
endmodule

// File: rtl/hpci_rsp_hold.sv
`timescale 1ns/1ps
// One-entry response register: loaded on acceptance, released on acknowledge.
module hpci_rsp_hold
   import hpci_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  dec_s dec_i,
   input  logic ack_i,
   output logic valid_o,
   output dec_s dec_o
);
   dec_s held;
   logic err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         held    <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (load_i) begin
            valid_o <= 1'b1;
            held    <= dec_i;
            err_q   <= dec_i.err;
         end else if (ack_i) begin
            valid_o <= 1'b0;
         end
      end
   end

   always_comb begin
      dec_o     = held;
      dec_o.err = err_q;
   end

   // R2, R13: a held response does not move until acknowledged
   assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ack_i) |=> (valid_o && $stable(held.tgt) && $stable(held.addr) && $stable(held.fill)));

   // R9: the error strobe never lasts two cycles
   assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> !err_q);

   // R10: an all-ones fill only accompanies the no-target code
   assert_fill_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && held.fill) |-> (held.tgt == TGT_NONE));
endmodule

// File: rtl/hpci_bridge_dec.sv
`timescale 1ns/1ps
module hpci_bridge_dec
   import hpci_pkg::*;
#(
   parameter int unsigned     DATA_W       = 64,
   parameter bit              DISCONTIG_EN = 1'b1,
   parameter int unsigned     CLR_BITS     = 8,
   parameter logic [PA_W-1:0] HOLE_LO = 32'h000A_0000,
   parameter logic [PA_W-1:0] HOLE_HI = 32'h000F_FFFF,
   parameter logic [PA_W-1:0] UNCL_LO = 32'h4000_0000,
   parameter logic [PA_W-1:0] UNCL_HI = 32'h7FFF_FFFF,
   parameter logic [PA_W-1:0] IOW_LO  = 32'hFE00_0000,
   parameter logic [PA_W-1:0] IOW_HI  = 32'hFEBF_FFFF,
   parameter logic [PA_W-1:0] RSV_LO  = 32'hFE01_0000,
   parameter logic [PA_W-1:0] RSV_HI  = 32'hFE7F_FFFF,
   parameter logic [PA_W-1:0] CFGA_LO = 32'hFEC0_0000,
   parameter logic [PA_W-1:0] CFGA_HI = 32'hFEDF_FFFF,
   parameter logic [PA_W-1:0] CFGD_LO = 32'hFEE0_0000,
   parameter logic [PA_W-1:0] CFGD_HI = 32'hFEEF_FFFF
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PA_W-1:0]   req_addr,
   input  logic              req_write,
   input  logic              req_inbound,
   input  logic              req_io,
   input  logic              mode_discontig,
   input  logic              mode_err_en,
   input  logic              mode_hole_host_pci,
   input  logic              mode_hole_pci_sys,
   input  logic [PA_W-1:0]   mode_mem_top,
   output logic              rsp_valid,
   input  logic              rsp_ack,
   output logic [2:0]        rsp_target,
   output logic [PA_W-1:0]   rsp_addr,
   output logic              rsp_err,
   output logic              rsp_fill,
   output logic [DATA_W-1:0] rsp_rdata
);
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("hpci_bridge_dec: DATA_W must be a whole number of bytes");
   end

   dec_s host_dec;
   dec_s pci_dec;
   dec_s next_dec;
   dec_s out_dec;
   logic accept;

   hpci_host_dec #(
      .HOLE_LO (HOLE_LO), .HOLE_HI (HOLE_HI),
      .UNCL_LO (UNCL_LO), .UNCL_HI (UNCL_HI),
      .IOW_LO  (IOW_LO),  .IOW_HI  (IOW_HI),
      .RSV_LO  (RSV_LO),  .RSV_HI  (RSV_HI),
      .CFGA_LO (CFGA_LO), .CFGA_HI (CFGA_HI),
      .CFGD_LO (CFGD_LO), .CFGD_HI (CFGD_HI),
      .CLR_BITS     (CLR_BITS),
      .DISCONTIG_EN (DISCONTIG_EN)
   ) u_host (
      .addr_i      (req_addr),
      .write_i     (req_write),
      .discontig_i (mode_discontig),
      .err_en_i    (mode_err_en),
      .hole_pci_i  (mode_hole_host_pci),
      .dec_o       (host_dec)
   );

   hpci_pci_dec #(
      .HOLE_LO (HOLE_LO),
      .HOLE_HI (HOLE_HI)
   ) u_pci (
      .addr_i     (req_addr),
      .io_i       (req_io),
      .hole_sys_i (mode_hole_pci_sys),
      .top_i      (mode_mem_top),
      .dec_o      (pci_dec)
   );

   assign next_dec = req_inbound ? pci_dec : host_dec;
   assign accept   = req_valid && req_ready;

   hpci_rsp_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .dec_i   (next_dec),
      .ack_i   (rsp_ack),
      .valid_o (rsp_valid),
      .dec_o   (out_dec)
   );

   assign req_ready  = !rsp_valid;
   assign rsp_target = out_dec.tgt;
   assign rsp_addr   = out_dec.addr;
   assign rsp_err    = out_dec.err;
   assign rsp_fill   = rsp_valid && out_dec.fill;
   assign rsp_rdata  = {DATA_W{rsp_fill}};

   // R2: acceptance yields a response on the next cycle and blocks new requests
   assert_accept_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (rsp_valid && !req_ready));

   // R2: an acknowledge frees the block on the following cycle
   assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ack) |=> !rsp_valid);

   // R5: forwarded PCI memory addresses never carry the top byte
   assert_pmem_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target == TGT_PCIMEM) |-> (rsp_addr[PA_W-1 -: CLR_BITS] == '0));

   // R8: configuration aliases ignore the address entirely
   assert_cfg_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_target == TGT_CFGADR || rsp_target == TGT_CFGDAT)) |-> (rsp_addr == '0));

   // R9: the error strobe appears only in the first response cycle, with the error code
   assert_err_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> ($rose(rsp_valid) && rsp_target == TGT_ERR));

   // R12: inbound I/O never produces a system memory cycle
   assert_inb_io_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_inbound && req_io) |=> (rsp_target == TGT_NONE && !rsp_err));
endmodule

// File: tb/hpci_bridge_dec_test.sv
`timescale 1ns/1ps
module hpci_bridge_dec_test;
   localparam int DW = 64;

   logic          clk;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [31:0]   req_addr;
   logic          req_write;
   logic          req_inbound;
   logic          req_io;
   logic          mode_discontig;
   logic          mode_err_en;
   logic          mode_hole_host_pci;
   logic          mode_hole_pci_sys;
   logic [31:0]   mode_mem_top;
   logic          rsp_valid;
   logic          rsp_ack;
   logic [2:0]    rsp_target;
   logic [31:0]   rsp_addr;
   logic          rsp_err;
   logic          rsp_fill;
   logic [DW-1:0] rsp_rdata;

   int checks = 0;
   int errors = 0;

   hpci_bridge_dec uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_write (req_write), .req_inbound (req_inbound), .req_io (req_io),
      .mode_discontig (mode_discontig), .mode_err_en (mode_err_en),
      .mode_hole_host_pci (mode_hole_host_pci), .mode_hole_pci_sys (mode_hole_pci_sys),
      .mode_mem_top (mode_mem_top),
      .rsp_valid (rsp_valid), .rsp_ack (rsp_ack), .rsp_target (rsp_target),
      .rsp_addr (rsp_addr), .rsp_err (rsp_err), .rsp_fill (rsp_fill), .rsp_rdata (rsp_rdata)
   );

   initial begin
      clk = 1'b0;
      forever #10 clk = ~clk;
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit in_rng(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction

   // expected response computed from the requirement text
   task automatic model(input logic [31:0] a, input bit wr, input bit inb, input bit io,
                        output logic [2:0] t, output logic [31:0] pa, output bit fl,
                        output bit er, output string tag);
      bit unc;
      unc = 0; t = 3'd0; pa = 32'h0; fl = 0; er = 0; tag = "R3";
      if (inb) begin
         if (io) begin
            tag = "R12";
         end else begin
            tag = "R11";
            if (a < 32'h000A_0000) t = 3'd1;
            else if (a <= 32'h000F_FFFF) t = mode_hole_pci_sys ? 3'd1 : 3'd0;
            else t = (a <= mode_mem_top) ? 3'd1 : 3'd0;
            if (t == 3'd1) pa = a;
         end
      end else if (in_rng(a, 32'h4000_0000, 32'h7FFF_FFFF)) begin
         unc = 1;
      end else if (a < 32'h4000_0000) begin
         if (in_rng(a, 32'h000A_0000, 32'h000F_FFFF)) begin
            tag = "R4";
            if (mode_hole_host_pci) begin t = 3'd2; pa = {8'h00, a[23:0]}; end
            else begin t = 3'd1; pa = a; end
         end else begin
            tag = "R3"; t = 3'd1; pa = a;
         end
      end else if (in_rng(a, 32'hFE00_0000, 32'hFEBF_FFFF)) begin
         if (mode_discontig) begin
            tag = "R7"; t = 3'd3; pa = 32'h0;
            for (int k = 9; k <= 19; k++) pa = {pa[30:0], a[31-k]};
            for (int k = 27; k <= 31; k++) pa = {pa[30:0], a[31-k]};
         end else if (in_rng(a, 32'hFE01_0000, 32'hFE7F_FFFF)) begin
            unc = 1; tag = "R6";
         end else begin
            tag = "R6"; t = 3'd3; pa = {8'h00, a[23:0]};
         end
      end else if (in_rng(a, 32'hFEC0_0000, 32'hFEDF_FFFF)) begin
         tag = "R8"; t = 3'd4;
      end else if (in_rng(a, 32'hFEE0_0000, 32'hFEEF_FFFF)) begin
         tag = "R8"; t = 3'd5;
      end else begin
         tag = "R5"; t = 3'd2; pa = {8'h00, a[23:0]};
      end
      if (unc) begin
         if (mode_err_en) begin t = 3'd6; er = 1; tag = {tag, "/R9"}; end
         else begin t = 3'd0; fl = !wr; tag = {tag, "/R10"}; end
      end
   endtask

   task automatic run_txn(input logic [31:0] a, input bit wr, input bit inb, input bit io, input bit flip);
      logic [2:0]  et;
      logic [31:0] ea;
      bit          ef, ee;
      string       tg;
      @(negedge clk);
      chk("R2", "ready before request", {63'h0, req_ready}, 64'h1);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_inbound = inb; req_io = io;
      model(a, wr, inb, io, et, ea, ef, ee, tg);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", "rsp_valid after accept", {63'h0, rsp_valid}, 64'h1);
      chk(tg, "target", {61'h0, rsp_target}, {61'h0, et});
      chk(tg, "address", {32'h0, rsp_addr}, {32'h0, ea});
      chk(tg, "fill", {63'h0, rsp_fill}, {63'h0, ef});
      chk("R10", "rdata", rsp_rdata, ef ? {DW{1'b1}} : {DW{1'b0}});
      chk("R9", "error strobe", {63'h0, rsp_err}, {63'h0, ee});
      if (flip) begin
         mode_discontig     = !mode_discontig;
         mode_err_en        = !mode_err_en;
         mode_hole_host_pci = !mode_hole_host_pci;
         mode_hole_pci_sys  = !mode_hole_pci_sys;
         mode_mem_top       = mode_mem_top ^ 32'h00F0_0000;
      end
      @(negedge clk);
      chk("R2", "still valid without ack", {63'h0, rsp_valid}, 64'h1);
      chk("R2", "ready low while held", {63'h0, req_ready}, 64'h0);
      chk("R13", "held target", {61'h0, rsp_target}, {61'h0, et});
      chk("R13", "held address", {32'h0, rsp_addr}, {32'h0, ea});
      chk("R9", "strobe gone in second cycle", {63'h0, rsp_err}, 64'h0);
      rsp_ack = 1'b1;
      @(negedge clk);
      rsp_ack = 1'b0;
      chk("R2", "released after ack", {63'h0, rsp_valid}, 64'h0);
   endtask

   task automatic set_mode(input bit dis, input bit een, input bit hhp, input bit hps, input logic [31:0] top);
      mode_discontig = dis; mode_err_en = een; mode_hole_host_pci = hhp;
      mode_hole_pci_sys = hps; mode_mem_top = top;
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] a;
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
      req_inbound = 1'b0; req_io = 1'b0; rsp_ack = 1'b0;
      set_mode(0, 1, 0, 0, 32'h00FF_FFFF);
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", {63'h0, rsp_valid}, 64'h0);
      chk("R1", "err in reset", {63'h0, rsp_err}, 64'h0);
      chk("R1", "ready in reset", {63'h0, req_ready}, 64'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", {63'h0, rsp_valid}, 64'h0);
      chk("R1", "ready after reset", {63'h0, req_ready}, 64'h1);

      // directed corners: R3 R4 R5
      run_txn(32'h0009_FFFF, 0, 0, 0, 0);
      run_txn(32'h3FFF_FFFF, 1, 0, 0, 0);
      run_txn(32'h000A_0000, 0, 0, 0, 0);
      set_mode(0, 1, 1, 0, 32'h00FF_FFFF);
      run_txn(32'h000A_0000, 0, 0, 0, 0);
      run_txn(32'h000F_FFFF, 1, 0, 0, 0);
      run_txn(32'h0010_0000, 0, 0, 0, 0);
      run_txn(32'h8000_0000, 0, 0, 0, 0);
      run_txn(32'hFDFF_FFFF, 1, 0, 0, 0);
      run_txn(32'hFEF0_0000, 0, 0, 0, 0);
      run_txn(32'hFFFF_FFFF, 0, 0, 0, 0);
      // R9 and R10 on the unclaimed window
      run_txn(32'h4000_0000, 0, 0, 0, 0);
      run_txn(32'h7FFF_FFFF, 1, 0, 0, 0);
      set_mode(0, 0, 0, 0, 32'h00FF_FFFF);
      run_txn(32'h4000_0000, 0, 0, 0, 0);
      run_txn(32'h7FFF_FFFC, 1, 0, 0, 0);
      // R6 contiguous window and reserved edges
      run_txn(32'hFE00_FFFF, 0, 0, 0, 0);
      run_txn(32'hFE01_0000, 0, 0, 0, 0);
      run_txn(32'hFE7F_FFFF, 1, 0, 0, 0);
      run_txn(32'hFE80_0000, 0, 0, 0, 0);
      run_txn(32'hFEBF_FFFF, 0, 0, 0, 0);
      set_mode(0, 1, 0, 0, 32'h00FF_FFFF);
      run_txn(32'hFE01_0000, 0, 0, 0, 0);
      // R7 bit gathering
      set_mode(1, 1, 0, 0, 32'h00FF_FFFF);
      run_txn(32'hFE12_3456, 0, 0, 0, 0);
      run_txn(32'hFE7F_F01F, 1, 0, 0, 0);
      run_txn(32'hFE00_0000, 0, 0, 0, 0);
      // R8 configuration aliases
      run_txn(32'hFEC0_0000, 0, 0, 0, 0);
      run_txn(32'hFEDF_FFFF, 1, 0, 0, 0);
      run_txn(32'hFEE0_0004, 0, 0, 0, 0);
      run_txn(32'hFEEF_FFFF, 1, 0, 0, 0);
      // R11 inbound memory, R12 inbound I/O
      run_txn(32'h00FF_FFFF, 0, 1, 0, 0);
      run_txn(32'h0100_0000, 0, 1, 0, 0);
      run_txn(32'h000B_0000, 0, 1, 0, 0);
      set_mode(1, 1, 0, 1, 32'h00FF_FFFF);
      run_txn(32'h000B_0000, 1, 1, 0, 0);
      run_txn(32'h0000_1000, 0, 1, 1, 0);
      run_txn(32'h4000_0000, 0, 1, 1, 0);
      // R13 mode change while held
      set_mode(0, 1, 0, 0, 32'h00FF_FFFF);
      run_txn(32'hFE01_2345, 0, 0, 0, 1);
      run_txn(32'h000C_0000, 0, 0, 0, 1);
      run_txn(32'h000C_0000, 0, 1, 0, 1);

      // constrained random
      void'($urandom(32'd24681357));
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         int          kind;
         r    = $urandom;
         kind = int'($urandom % 6);
         case (kind)
            0: a = r & 32'h001F_FFFF;
            1: a = {8'hFE, r[23:0]};
            2: a = {2'b01, r[29:0]};
            3: a = {8'hFE, 4'h0, r[19:0]};
            default: a = r;
         endcase
         set_mode(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 2) ? {8'h00, 4'h0, r[27:8]} : {1'b0, r[30:0]});
         run_txn(a, 1'($urandom), ($urandom % 4) == 0, 1'($urandom), ($urandom % 4) == 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule